// File: doc/BRIEF.md
# Emergency Payload Capture and Flush Controller

This block sits on the emergency shutdown path of a storage controller. A host sends 16-bit words in pairs: a command word followed by a data word. Once emergency mode has been entered and the block reports ready, each payload command deposits three bytes into an internal buffer. The first byte comes from the low half of the command word. The second and third bytes come from the data word. A flush command then makes the block copy every buffered byte, one per transfer, into a reserved region of an external memory. When the copy is done, the block raises a power-down flag and freezes.

The entry sequence is modelled with plain control pins. A background job can be started. An abort request cancels that job after a fixed number of cycles, and the busy flag shows the job state. An emergency-mode request, honoured only while no job is busy, drops the ready flag for a fixed settling time. The host word stream never back-pressures, so payload can arrive back to back. The memory write port is valid/ready in spirit: a byte moves on every cycle where `mem_valid` is high and `mem_busy` is low. While `mem_busy` is high, address and data hold.

Top module: `emg_flush_ctrl`

## Requirements
- R1: After reset: stat_busy=0, stat_em=0, stat_ready=1, stat_pd=0, stat_err=0, mem_valid=0, and host_ready=1 at all times.
- R2: Host words are taken on every cycle with host_valid=1. Idle cycles do not disturb pairing. Odd words are commands and even words are data. A command whose bits 15..8 equal 0x45 is a payload command, and its bytes enter the buffer in the order: command bits 7..0, data bits 15..8, data bits 7..0.
- R3: A payload command is stored only when stat_em=1 and stat_ready=1. Otherwise it is dropped and stat_err is set.
- R4: The buffer holds DEPTH_CMDS payload commands (default 682, that is 2046 bytes). A further payload command is dropped and sets stat_err.
- R5: A command word equal to 0x4F00, followed by a data word of any value, starts the flush. Buffered bytes leave in arrival order at addresses BASE_ADDR, BASE_ADDR+1, and so on upward.
- R6: A byte transfers on a cycle where mem_valid=1 and mem_busy=0. While mem_busy=1, mem_valid, mem_addr and mem_data hold.
- R7: stat_pd rises on the edge that completes the last transfer, and mem_valid is low from then on.
- R8: A flush with an empty buffer writes nothing, and stat_pd is high on the edge that takes the dummy word.
- R9: A flush command received while stat_em=0 or stat_ready=0 is dropped and sets stat_err.
- R10: Any other command word is ignored together with its data word, even when that data word looks like an opcode.
- R11: job_start with no job running and emergency mode off sets stat_busy. abort_req while busy clears stat_busy exactly ABORT_CYC cycles after the request edge.
- R12: em_req while stat_busy=0 sets stat_em and clears stat_ready on the next edge. stat_ready returns READY_CYC cycles after the request edge. em_req while busy is ignored.
- R13: From the start of a flush until reset, host words, job_start, abort_req and em_req have no effect on outputs.
- R14: stat_err, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host word present this cycle |
| host_word | input | 16 | Host command or data word |
| host_ready | output | 1 | Always high, no back-pressure |
| job_start | input | 1 | Start a background job (pulse) |
| abort_req | input | 1 | Cancel the running job (pulse) |
| em_req | input | 1 | Request emergency mode (pulse) |
| mem_valid | output | 1 | Byte offered to memory |
| mem_addr | output | ADDR_W | Byte address in reserved region |
| mem_data | output | 8 | Byte to write |
| mem_busy | input | 1 | Memory cannot take a byte this cycle |
| stat_busy | output | 1 | Background job running |
| stat_em | output | 1 | Emergency mode on |
| stat_ready | output | 1 | Ready for payload |
| stat_pd | output | 1 | Flush complete, powered down |
| stat_err | output | 1 | Sticky protocol error |

## Verification
The assertions assume that a reset comes first and that mem_busy may change freely on any cycle. They also assume the host always sends whole command/data pairs, because the phase tracker cannot recover from a lost word. The stimulus sends only complete pairs, with random idle gaps between words. It drives mem_busy from a random draw or holds it low, and it pulses control pins for a single cycle. Under these conditions the checks on held outputs, address steps, sticky flags and the gating of emergency entry all hold.

// File: rtl/emg_pkg.sv
package emg_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int LANES  = 3;
  localparam int PAY_W  = LANES * BYTE_W;
  localparam logic [7:0]  OP_PAYLOAD = 8'h45;
  localparam logic [15:0] OP_FLUSH   = 16'h4F00;

  typedef enum logic [1:0] {K_NONE, K_PAY, K_FLUSH} cmd_kind_t;
  typedef enum logic [1:0] {FL_IDLE, FL_RUN, FL_DONE} flush_st_t;
endpackage

// File: rtl/emg_cmd_dec.sv
module emg_cmd_dec
  import emg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word,
  output logic              pay_evt,
  output logic              flush_evt,
  output logic [PAY_W-1:0]  pay_bytes
);
  logic              phase_q;   // 0: expecting command, 1: expecting data
  cmd_kind_t         kind_q;
  logic [BYTE_W-1:0] first_q;
  cmd_kind_t         kind_d;

  always_comb begin
    if (word[15:8] == OP_PAYLOAD)  kind_d = K_PAY;
    else if (word == OP_FLUSH)     kind_d = K_FLUSH;
    else                           kind_d = K_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      kind_q  <= K_NONE;
      first_q <= '0;
    end else if (word_valid) begin
      if (!phase_q) begin
        phase_q <= 1'b1;
        kind_q  <= kind_d;
        first_q <= word[BYTE_W-1:0];
      end else begin
        phase_q <= 1'b0;
        kind_q  <= K_NONE;
      end
    end
  end

  logic data_fire;
  assign data_fire = word_valid && phase_q;
  assign pay_evt   = data_fire && (kind_q == K_PAY);
  assign flush_evt = data_fire && (kind_q == K_FLUSH);
  assign pay_bytes = {first_q, word};
endmodule

// File: rtl/emg_delay.sv
module emg_delay #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic running,
  output logic done
);
  localparam int CW = (CYC > 1) ? $clog2(CYC + 1) : 1;
  logic          act_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start && !act_q) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (cnt_q == CW'(CYC - 1)) act_q <= 1'b0;
      else                       cnt_q <= cnt_q + CW'(1);
    end
  end

  assign running = act_q;
  assign done    = act_q && (cnt_q == CW'(CYC - 1));
endmodule

// File: rtl/emg_entry_seq.sv
module emg_entry_seq #(
  parameter int ABORT_CYC = 15,
  parameter int READY_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frozen,
  input  logic job_start,
  input  logic abort_req,
  input  logic em_req,
  output logic busy,
  output logic em_on,
  output logic ready
);
  logic busy_q, em_q, ready_q;
  logic ab_start, ab_run, ab_done;
  logic em_go, rd_run, rd_done;

  assign ab_start = abort_req && busy_q && !ab_run && !frozen;
  assign em_go    = em_req && !busy_q && !em_q && !frozen;

  emg_delay #(.CYC(ABORT_CYC)) u_abort_dly (
    .clk(clk), .rst_n(rst_n), .start(ab_start), .running(ab_run), .done(ab_done)
  );

  emg_delay #(.CYC(READY_CYC)) u_ready_dly (
    .clk(clk), .rst_n(rst_n), .start(em_go), .running(rd_run), .done(rd_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      em_q    <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      if (ab_done)
        busy_q <= 1'b0;
      else if (job_start && !busy_q && !em_q && !frozen)
        busy_q <= 1'b1;
      if (em_go) begin
        em_q    <= 1'b1;
        ready_q <= 1'b0;
      end else if (rd_done && rd_run) begin
        ready_q <= 1'b1;
      end
    end
  end

  assign busy  = busy_q;
  assign em_on = em_q;
  assign ready = ready_q;
endmodule

// File: rtl/emg_pay_buf.sv
module emg_pay_buf
  import emg_pkg::*;
#(
  parameter int DEPTH = 682,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PAY_W-1:0] wr_data,
  input  logic [CNT_W-1:0] rd_idx,
  output logic [PAY_W-1:0] rd_data,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PAY_W-1:0] store [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign full = (cnt_q == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_en && !full) store[cnt_q[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (wr_en && !full)   cnt_q <= cnt_q + CNT_W'(1);
  end

  assign rd_data = store[rd_idx[AW-1:0]];
  assign count   = cnt_q;
endmodule

// File: rtl/emg_flush_eng.sv
module emg_flush_eng
  import emg_pkg::*;
#(
  parameter int DEPTH  = 682,
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  count,
  input  logic [PAY_W-1:0]  rd_data,
  input  logic              mem_busy,
  output logic [CNT_W-1:0]  rd_idx,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_data,
  output logic              running,
  output logic              pd
);
  localparam int BW = $clog2(LANES * DEPTH + 1);

  flush_st_t     st_q;
  logic [CNT_W-1:0] idx_q;
  logic [1:0]       sel_q;
  logic [BW-1:0]    byte_q;
  logic [BYTE_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = rd_data[PAY_W-1-BYTE_W*g -: BYTE_W];
  end

  logic fire, last_lane, last_word;
  assign fire      = (st_q == FL_RUN) && !mem_busy;
  assign last_lane = (sel_q == 2'(LANES - 1));
  assign last_word = (idx_q == count - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= FL_IDLE;
      idx_q  <= '0;
      sel_q  <= '0;
      byte_q <= '0;
    end else begin
      case (st_q)
        FL_IDLE: if (start) begin
          st_q   <= (count == '0) ? FL_DONE : FL_RUN;
          idx_q  <= '0;
          sel_q  <= '0;
          byte_q <= '0;
        end
        FL_RUN: if (fire) begin
          byte_q <= byte_q + BW'(1);
          if (last_lane) begin
            sel_q <= '0;
            if (last_word) st_q  <= FL_DONE;
            else           idx_q <= idx_q + CNT_W'(1);
          end else begin
            sel_q <= sel_q + 2'd1;
          end
        end
        default: st_q <= FL_DONE;
      endcase
    end
  end

  assign rd_idx    = idx_q;
  assign mem_valid = (st_q == FL_RUN);
  assign mem_addr  = BASE_ADDR + ADDR_W'(byte_q);
  assign mem_data  = lane[sel_q];
  assign running   = (st_q != FL_IDLE);
  assign pd        = (st_q == FL_DONE);
endmodule

// File: rtl/emg_flush_ctrl.sv
module emg_flush_ctrl
  import emg_pkg::*;
#(
  parameter int DEPTH_CMDS = 682,
  parameter int ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h3_0000,
  parameter int ABORT_CYC  = 15,
  parameter int READY_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic [15:0]       host_word,
  output logic              host_ready,
  input  logic              job_start,
  input  logic              abort_req,
  input  logic              em_req,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data,
  input  logic              mem_busy,
  output logic              stat_busy,
  output logic              stat_em,
  output logic              stat_ready,
  output logic              stat_pd,
  output logic              stat_err
);
  localparam int CNT_W = $clog2(DEPTH_CMDS + 1);

  logic             pay_evt, flush_evt;
  logic [PAY_W-1:0] pay_bytes, rd_data;
  logic [CNT_W-1:0] count, rd_idx;
  logic             full, frozen, em_on, ready;
  logic             accept_ok, pay_ok, flush_ok, bad_evt;
  logic             err_q;

  assign host_ready = 1'b1;

  emg_cmd_dec u_dec (
    .clk(clk), .rst_n(rst_n), .word_valid(host_valid), .word(host_word),
    .pay_evt(pay_evt), .flush_evt(flush_evt), .pay_bytes(pay_bytes)
  );

  emg_entry_seq #(.ABORT_CYC(ABORT_CYC), .READY_CYC(READY_CYC)) u_entry (
    .clk(clk), .rst_n(rst_n), .frozen(frozen), .job_start(job_start),
    .abort_req(abort_req), .em_req(em_req),
    .busy(stat_busy), .em_on(em_on), .ready(ready)
  );

  assign accept_ok = em_on && ready && !frozen;
  assign pay_ok    = pay_evt && accept_ok && !full;
  assign flush_ok  = flush_evt && accept_ok;
  assign bad_evt   = !frozen && ((pay_evt && !(accept_ok && !full)) ||
                                 (flush_evt && !accept_ok));

  emg_pay_buf #(.DEPTH(DEPTH_CMDS)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(pay_ok), .wr_data(pay_bytes),
    .rd_idx(rd_idx), .rd_data(rd_data), .count(count), .full(full)
  );

  emg_flush_eng #(.DEPTH(DEPTH_CMDS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_flush (
    .clk(clk), .rst_n(rst_n), .start(flush_ok), .count(count), .rd_data(rd_data),
    .mem_busy(mem_busy), .rd_idx(rd_idx), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .running(frozen), .pd(stat_pd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (bad_evt) err_q <= 1'b1;
  end

  assign stat_em    = em_on;
  assign stat_ready = ready;
  assign stat_err   = err_q;
endmodule

// File: rtl/emg_flush_ctrl_chk.sv
module emg_flush_ctrl_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_busy,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_data,
  input logic              stat_busy,
  input logic              stat_em,
  input logic              stat_ready,
  input logic              stat_pd,
  input logic              stat_err
);
  assert_hold_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_busy) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_busy) |=> (!mem_valid || mem_addr == $past(mem_addr) + ADDR_W'(1)));

  assert_pd_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pd |=> stat_pd);

  assert_quiet_after_pd_R13: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pd |-> !mem_valid);

  assert_err_sticky_R14: assert property (@(posedge clk) disable iff (!rst_n)
    stat_err |=> stat_err);

  assert_em_needs_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_em) |-> !$past(stat_busy));

  assert_ready_low_in_em_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_ready |-> stat_em);

  assert_write_needs_em_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> stat_em);
endmodule

bind emg_flush_ctrl emg_flush_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_busy(mem_busy),
  .mem_addr(mem_addr), .mem_data(mem_data), .stat_busy(stat_busy),
  .stat_em(stat_em), .stat_ready(stat_ready), .stat_pd(stat_pd), .stat_err(stat_err)
);

// File: tb/emg_flush_ctrl_tb.sv
module emg_flush_ctrl_tb;
  localparam int DEPTH = 682;
  localparam int AW    = 20;
  localparam logic [AW-1:0] BASE = 20'h3_0000;
  localparam int ABORT = 15;
  localparam int READY = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_valid = 1'b0, job_start = 1'b0, abort_req = 1'b0, em_req = 1'b0;
  logic mem_busy = 1'b0;
  logic [15:0] host_word = '0;
  logic host_ready, mem_valid, stat_busy, stat_em, stat_ready, stat_pd, stat_err;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;

  int total = 0, fails = 0, cyc = 0, last_fire_cyc = 0, busy_pct = 0;
  bit pd_seen = 0, hold_prev = 0;
  logic [AW-1:0] prev_addr;
  logic [7:0] prev_data;
  logic [7:0] exp_q[$];
  logic [7:0] got_d[$];
  logic [AW-1:0] got_a[$];

  always #4 clk = ~clk;

  emg_flush_ctrl #(.DEPTH_CMDS(DEPTH), .ADDR_W(AW), .BASE_ADDR(BASE),
                   .ABORT_CYC(ABORT), .READY_CYC(READY)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_word(host_word),
    .host_ready(host_ready), .job_start(job_start), .abort_req(abort_req),
    .em_req(em_req), .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_busy(mem_busy), .stat_busy(stat_busy), .stat_em(stat_em),
    .stat_ready(stat_ready), .stat_pd(stat_pd), .stat_err(stat_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input int i);
    return BASE + AW'(i);
  endfunction

  // memory-side model: decide busy, record transfers, check holding (R6) and pd timing (R7)
  always @(negedge clk) begin
    cyc++;
    if (hold_prev)
      chk(mem_valid && mem_addr == prev_addr && mem_data == prev_data,
          "R6 hold under busy", {12'(mem_addr), mem_data, 11'd0, mem_valid},
          {12'(prev_addr), prev_data, 12'd1});
    if (stat_pd && !pd_seen) begin
      pd_seen = 1;
      if (got_d.size() > 0)
        chk(last_fire_cyc == cyc - 1 && !mem_valid, "R7 pd after last byte",
            32'(cyc - last_fire_cyc), 32'd1);
    end
    mem_busy = (busy_pct > 0) && (($urandom % 100) < busy_pct);
    if (mem_valid && !mem_busy) begin
      got_d.push_back(mem_data);
      got_a.push_back(mem_addr);
      last_fire_cyc = cyc;
    end
    hold_prev = mem_valid && mem_busy;
    prev_addr = mem_addr;
    prev_data = mem_data;
  end

  task automatic do_reset();
    rst_n = 0; host_valid = 0; job_start = 0; abort_req = 0; em_req = 0; busy_pct = 0;
    repeat (3) @(negedge clk);
    exp_q.delete(); got_d.delete(); got_a.delete(); pd_seen = 0;
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w, input bit gaps);
    if (gaps) repeat ($urandom % 3) @(negedge clk);
    host_valid = 1; host_word = w;
    @(negedge clk);
    host_valid = 0; host_word = $urandom;
  endtask

  task automatic send_pair(input logic [15:0] c, input logic [15:0] d, input bit gaps);
    send_word(c, gaps);
    send_word(d, gaps);
  endtask

  task automatic pulse(input int which);
    if (which == 0) job_start = 1; else if (which == 1) abort_req = 1; else em_req = 1;
    @(negedge clk);
    job_start = 0; abort_req = 0; em_req = 0;
  endtask

  task automatic enter_em();
    pulse(2);
    repeat (READY + 1) @(negedge clk);
  endtask

  task automatic wait_pd();
    for (int g = 0; g < 20000 && !stat_pd; g++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compare_out(input string req);
    int bad = 0;
    chk(got_d.size() == exp_q.size(), req, got_d.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_d.size(); i++)
      if (got_d[i] !== exp_q[i] || got_a[i] !== exp_addr(i)) begin
        if (bad == 0) chk(0, req, {got_a[i][15:0], 8'd0, got_d[i]}, {exp_addr(i)[15:0], 8'd0, exp_q[i]});
        bad++;
      end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1 reset state
    do_reset();
    chk(!stat_busy && !stat_em && stat_ready && !stat_pd && !stat_err && !mem_valid && host_ready,
        "R1 reset", {stat_busy, stat_em, stat_ready, stat_pd, stat_err, mem_valid, host_ready},
        7'b0010001);

    // R11 / R12: job, em refused while busy, timed abort
    pulse(0);
    chk(stat_busy, "R11 job busy", stat_busy, 1);
    pulse(2);
    chk(!stat_em && stat_ready, "R12 em ignored while busy", {stat_em, stat_ready}, 2'b01);
    pulse(1);
    repeat (ABORT - 1) @(negedge clk);
    chk(stat_busy, "R11 busy before abort latency", stat_busy, 1);
    @(negedge clk);
    chk(!stat_busy, "R11 busy cleared at abort latency", stat_busy, 0);

    // R12 entry timing, R3 payload while not ready
    pulse(2);
    chk(stat_em && !stat_ready, "R12 em on ready low", {stat_em, stat_ready}, 2'b10);
    repeat (READY - 1) @(negedge clk);
    chk(!stat_ready, "R12 ready still low", stat_ready, 0);
    @(negedge clk);
    chk(stat_ready, "R12 ready back", stat_ready, 1);

    do_reset();
    send_pair(16'h4511, 16'h2233, 0);
    chk(stat_err && !stat_em, "R3 payload outside em", {stat_em, stat_err}, 2'b01);
    do_reset();
    pulse(2);
    send_pair(16'h4511, 16'h2233, 0);
    chk(stat_err, "R3 payload while not ready", stat_err, 1);
    repeat (READY) @(negedge clk);
    send_pair(16'h4F00, 16'h0000, 0);
    chk(stat_pd, "R3 dropped payload leaves empty flush", stat_pd, 1);
    chk(got_d.size() == 0, "R3 nothing written", got_d.size(), 0);

    // R9 flush outside em
    do_reset();
    send_pair(16'h4F00, 16'hABCD, 0);
    repeat (2) @(negedge clk);
    chk(!stat_pd && stat_err && got_d.size() == 0, "R9 flush refused",
        {stat_pd, stat_err}, 2'b01);

    // R10 other command with opcode-like data, then R8 empty flush
    do_reset();
    enter_em();
    send_pair(16'h1234, 16'h4F00, 0);
    send_pair(16'h2000, 16'h45AA, 0);
    repeat (2) @(negedge clk);
    chk(!stat_pd && !stat_err && !mem_valid, "R10 other commands ignored",
        {stat_pd, stat_err, mem_valid}, 3'b000);
    send_pair(16'h4F00, 16'hFFFF, 0);
    chk(stat_pd && !mem_valid, "R8 empty flush pd at once", {stat_pd, mem_valid}, 2'b10);
    repeat (4) @(negedge clk);
    chk(got_d.size() == 0 && !stat_err, "R8 empty flush writes nothing", got_d.size(), 0);

    // R2 R5 R6 R7 R13: random payload with gaps and random memory stalls
    for (int r = 0; r < 3; r++) begin
      int n;
      do_reset();
      busy_pct = (r == 0) ? 0 : 30 * r;
      enter_em();
      n = $urandom_range(1, 40);
      for (int i = 0; i < n; i++) begin
        logic [7:0] b0, b1, b2;
        b0 = $urandom; b1 = $urandom; b2 = $urandom;
        if ($urandom % 4 == 0) send_pair({8'h10 + 8'($urandom % 48), 8'($urandom)}, 16'($urandom), 1);
        send_pair({8'h45, b0}, {b1, b2}, r == 2);
        exp_q.push_back(b0); exp_q.push_back(b1); exp_q.push_back(b2);
      end
      chk(!stat_err && !mem_valid, "R2 payload accepted quietly", {stat_err, mem_valid}, 0);
      send_pair(16'h4F00, 16'($urandom), 0);
      send_pair(16'h45EE, 16'hEEEE, 0);
      pulse(2);
      wait_pd();
      compare_out("R5 flush bytes and addresses");
      chk(stat_pd && !stat_err, "R13 words during flush ignored", {stat_pd, stat_err}, 2'b10);
      send_pair(16'h4501, 16'h0203, 0);
      send_pair(16'h4F00, 16'h0000, 0);
      pulse(0);
      repeat (3) @(negedge clk);
      chk(got_d.size() == exp_q.size() && stat_pd && !stat_err && !stat_busy,
          "R13 frozen after pd", got_d.size(), exp_q.size());
    end

    // R4 capacity and R14 sticky error
    do_reset();
    enter_em();
    for (int i = 0; i < DEPTH; i++) begin
      logic [15:0] v;
      v = 16'(i);
      send_pair({8'h45, v[7:0]}, {~v[7:0], v[15:8]}, 0);
      exp_q.push_back(v[7:0]); exp_q.push_back(~v[7:0]); exp_q.push_back(v[15:8]);
    end
    chk(!stat_err, "R4 full buffer accepted", stat_err, 0);
    send_pair(16'h45FF, 16'hFFFF, 0);
    chk(stat_err, "R4 overflow dropped with error", stat_err, 1);
    send_pair(16'h4F00, 16'h0000, 0);
    wait_pd();
    compare_out("R4 full flush");
    chk(stat_err, "R14 error still set", stat_err, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule